// File: doc/BRIEF.md
# Cache Miss Type Classifier

This block watches a stream of memory block addresses and sorts every access into one of four outcomes for a set-associative cache under test: a hit, a conflict miss, a capacity miss or a compulsory miss. It stores tags only and never holds data. Each access updates two tag stores in the same cycle. One is the set-associative cache being studied. The other is a fully associative shadow cache with the same total number of lines. Both stores replace by least-recently-used order.

When the cache under test misses and the shadow hits, the miss came from limited associativity and counts as a conflict miss. When both miss, a first-touch table decides the category. A block never seen since reset gives a compulsory miss, and any other block gives a capacity miss. Each access produces a result one cycle later. Four saturating counters keep running totals, one for each category. These totals let a designer compare associativity choices on a recorded address trace.

Top module: `miss_classifier`

## Requirements
- R1: One cycle after a clock edge that samples `addr_valid_i` high, `res_valid_o` is high and `res_kind_o` carries the outcome. The encoding is 0 hit, 1 conflict, 2 capacity, 3 compulsory. A cycle with no strobe gives `res_valid_o` low in the next cycle.
- R2: An access is a hit when its block is present in its set. The set is selected by the low log2(SETS) address bits (bits 1:0 with defaults) and the tag is the remaining bits.
- R3: An access that misses in the cache under test while the 16-line fully associative shadow holds the block is a conflict miss.
- R4: An access that misses in both caches to a block address not seen since reset is a compulsory miss.
- R5: An access that misses in both caches to a block address seen before is a capacity miss.
- R6: Each set keeps a full recency order over its 4 ways. A hit or fill makes the line most recent. A miss in a full set evicts the least recent line. A set receives 4 distinct blocks without evicting any of them, because fills take invalid ways first.
- R7: Each category has a 16-bit counter that increments in the same cycle its result appears and holds at 65535 instead of wrapping.
- R8: A synchronous active-high reset clears the counters, both caches' contents and the first-touch history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid_i | input | 1 | Access strobe |
| addr_i | input | ADDR_W (8) | Block address of the access |
| res_valid_o | output | 1 | Result valid, one cycle after the strobe |
| res_kind_o | output | 2 | Outcome: 0 hit, 1 conflict, 2 capacity, 3 compulsory |
| cnt_hit_o | output | CNT_W (16) | Saturating hit count |
| cnt_conflict_o | output | CNT_W (16) | Saturating conflict miss count |
| cnt_capacity_o | output | CNT_W (16) | Saturating capacity miss count |
| cnt_compulsory_o | output | CNT_W (16) | Saturating compulsory miss count |

## Verification
The assertions assume that reset is held on the first clock edge. They also assume that `addr_i` is a complete block address whenever `addr_valid_i` is high, so the recorded first-touch bit points at a defined entry. The stimulus starts every scenario with a reset and changes the address and the strobe only on falling clock edges. Each address sequence is chosen so that the recency order of one set and of the shadow is known at every step. That includes accesses back to back over more than 65535 cycles to push the hit counter into saturation.

// File: rtl/miss_cls_pkg.sv
package miss_cls_pkg;
  typedef enum logic [1:0] {
    KIND_HIT        = 2'd0,
    KIND_CONFLICT   = 2'd1,
    KIND_CAPACITY   = 2'd2,
    KIND_COMPULSORY = 2'd3
  } miss_kind_e;

  localparam int NUM_KINDS = 4;
endpackage

// File: rtl/lru_tag_set.sv
// One recency-ordered tag store: a single set of WAYS lines.
// rank 0 is most recent, rank WAYS-1 is the eviction candidate.
module lru_tag_set #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_en,
  input  logic [TAG_W-1:0] acc_tag,
  output logic             hit
);
  localparam int RW = $clog2(WAYS);

  logic [TAG_W-1:0] tag_q  [WAYS];
  logic [RW-1:0]    rank_q [WAYS];
  logic [WAYS-1:0]  vld_q;

  logic [WAYS-1:0]  hit_vec;
  logic [RW-1:0]    hit_idx, inv_idx, lru_idx, tgt_idx, tgt_rank;
  logic             any_inv;

  always_comb begin
    hit_idx = '0;
    inv_idx = '0;
    lru_idx = '0;
    any_inv = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = vld_q[w] && (tag_q[w] == acc_tag);
      if (hit_vec[w]) hit_idx = RW'(w);
      if (rank_q[w] == RW'(WAYS - 1)) lru_idx = RW'(w);
    end
    // lowest-numbered invalid way wins
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_q[w]) begin
        inv_idx = RW'(w);
        any_inv = 1'b1;
      end
    end
    hit      = |hit_vec;
    tgt_idx  = hit ? hit_idx : (any_inv ? inv_idx : lru_idx);
    tgt_rank = rank_q[tgt_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      for (int w = 0; w < WAYS; w++) begin
        tag_q[w]  <= '0;
        rank_q[w] <= RW'(w);
      end
    end else if (acc_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (RW'(w) == tgt_idx)         rank_q[w] <= '0;
        else if (rank_q[w] < tgt_rank) rank_q[w] <= rank_q[w] + 1'b1;
      end
      tag_q[tgt_idx] <= acc_tag;
      vld_q[tgt_idx] <= 1'b1;
    end
  end

  // R2
  hit_unique_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R6
  mru_single_chk: assert property (@(posedge clk) disable iff (rst)
    acc_en |=> (rank_q[$past(tgt_idx)] == '0));
endmodule

// File: rtl/first_touch_table.sv
// One bit per block address, set on first access.
module first_touch_table #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              seen
);
  localparam int ENTRIES = 1 << ADDR_W;

  logic [ENTRIES-1:0] seen_q;

  assign seen = seen_q[acc_addr];

  always_ff @(posedge clk) begin
    if (rst)         seen_q <= '0;
    else if (acc_en) seen_q[acc_addr] <= 1'b1;
  end

  // R4
  mark_chk: assert property (@(posedge clk) disable iff (rst)
    acc_en |=> seen_q[$past(acc_addr)]);
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst)                     value <= '0;
    else if (inc && value != MAXV) value <= value + 1'b1;
  end

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(value) == MAXV) |-> (value == MAXV));

  // R7
  step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (value == $past(value) || value == $past(value) + 1'b1));
endmodule

// File: rtl/miss_classifier.sv
module miss_classifier
  import miss_cls_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              res_valid_o,
  output logic [1:0]        res_kind_o,
  output logic [CNT_W-1:0]  cnt_hit_o,
  output logic [CNT_W-1:0]  cnt_conflict_o,
  output logic [CNT_W-1:0]  cnt_capacity_o,
  output logic [CNT_W-1:0]  cnt_compulsory_o
);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - SET_W;
  localparam int LINES = SETS * WAYS;

  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] set_tag;
  logic [SETS-1:0]  set_hit;
  logic             dut_hit, shadow_hit, seen;
  miss_kind_e       kind_d;

  assign set_idx = addr_i[SET_W-1:0];
  assign set_tag = addr_i[ADDR_W-1:SET_W];

  // cache under test: one recency-ordered store per set
  for (genvar s = 0; s < SETS; s++) begin : g_set
    lru_tag_set #(.WAYS(WAYS), .TAG_W(TAG_W)) u_set (
      .clk    (clk),
      .rst    (rst),
      .acc_en (addr_valid_i && (set_idx == SET_W'(s))),
      .acc_tag(set_tag),
      .hit    (set_hit[s])
    );
  end

  assign dut_hit = set_hit[set_idx];

  // fully associative shadow of equal line count
  lru_tag_set #(.WAYS(LINES), .TAG_W(ADDR_W)) u_shadow (
    .clk    (clk),
    .rst    (rst),
    .acc_en (addr_valid_i),
    .acc_tag(addr_i),
    .hit    (shadow_hit)
  );

  first_touch_table #(.ADDR_W(ADDR_W)) u_touch (
    .clk     (clk),
    .rst     (rst),
    .acc_en  (addr_valid_i),
    .acc_addr(addr_i),
    .seen    (seen)
  );

  always_comb begin
    if (dut_hit)         kind_d = KIND_HIT;
    else if (shadow_hit) kind_d = KIND_CONFLICT;
    else if (!seen)      kind_d = KIND_COMPULSORY;
    else                 kind_d = KIND_CAPACITY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_o <= 1'b0;
      res_kind_o  <= 2'd0;
    end else begin
      res_valid_o <= addr_valid_i;
      if (addr_valid_i) res_kind_o <= kind_d;
    end
  end

  logic [CNT_W-1:0] cnt [NUM_KINDS];

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_cnt
    sat_counter #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .inc  (addr_valid_i && (kind_d == miss_kind_e'(k))),
      .value(cnt[k])
    );
  end

  assign cnt_hit_o        = cnt[KIND_HIT];
  assign cnt_conflict_o   = cnt[KIND_CONFLICT];
  assign cnt_capacity_o   = cnt[KIND_CAPACITY];
  assign cnt_compulsory_o = cnt[KIND_COMPULSORY];

  // R1
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    addr_valid_i |=> res_valid_o);

  // R1
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !addr_valid_i |=> !res_valid_o);

  // R4
  compulsory_once_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_valid_i && $past(addr_valid_i) && addr_i == $past(addr_i))
      |-> (kind_d != KIND_COMPULSORY));
endmodule

// File: tb/miss_classifier_tb.sv
module miss_classifier_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addr_valid_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        res_valid_o;
  logic [1:0]  res_kind_o;
  logic [15:0] cnt_hit_o, cnt_conflict_o, cnt_capacity_o, cnt_compulsory_o;

  int n_checks = 0;
  int n_fail   = 0;

  localparam int K_HIT = 0, K_CONF = 1, K_CAP = 2, K_COMP = 3;

  always #10 clk = ~clk;  // 50 MHz

  miss_classifier u_dut (
    .clk(clk), .rst(rst), .addr_valid_i(addr_valid_i), .addr_i(addr_i),
    .res_valid_o(res_valid_o), .res_kind_o(res_kind_o),
    .cnt_hit_o(cnt_hit_o), .cnt_conflict_o(cnt_conflict_o),
    .cnt_capacity_o(cnt_capacity_o), .cnt_compulsory_o(cnt_compulsory_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; addr_valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // one strobe, then result checked at the next falling edge
  task automatic access(input logic [7:0] a, input int exp_kind, input string req);
    @(negedge clk);
    addr_valid_i = 1'b1; addr_i = a;
    @(negedge clk);
    addr_valid_i = 1'b0;
    check({req, " valid"}, int'(res_valid_o), 1);
    check({req, " kind"}, int'(res_kind_o), exp_kind);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R8 reset valid", int'(res_valid_o), 0);
    check("R8 reset hit cnt", int'(cnt_hit_o), 0);
    check("R8 reset conflict cnt", int'(cnt_conflict_o), 0);
    check("R8 reset capacity cnt", int'(cnt_capacity_o), 0);
    check("R8 reset compulsory cnt", int'(cnt_compulsory_o), 0);
  endtask

  task automatic t_first_then_hit();
    do_reset();
    access(8'h00, K_COMP, "R4 first touch");
    access(8'h00, K_HIT, "R2 repeat");
    access(8'h01, K_COMP, "R4 other set");
    access(8'h01, K_HIT, "R2 other set repeat");
    check("R7 hit cnt", int'(cnt_hit_o), 2);
    check("R7 compulsory cnt", int'(cnt_compulsory_o), 2);
  endtask

  task automatic t_idle();
    @(negedge clk);
    @(negedge clk);
    check("R1 idle valid", int'(res_valid_o), 0);
    check("R1 idle counters stable", int'(cnt_hit_o), 2);
  endtask

  task automatic t_fill_and_conflict();
    do_reset();
    access(8'h00, K_COMP, "R6 fill a");
    access(8'h04, K_COMP, "R6 fill b");
    access(8'h08, K_COMP, "R6 fill c");
    access(8'h0C, K_COMP, "R6 fill d");
    access(8'h00, K_HIT, "R6 four resident a");
    access(8'h04, K_HIT, "R6 four resident b");
    access(8'h08, K_HIT, "R6 four resident c");
    access(8'h0C, K_HIT, "R6 four resident d");
    access(8'h10, K_COMP, "R6 fifth evicts");
    access(8'h00, K_CONF, "R3 evicted lru");
    access(8'h08, K_HIT, "R6 recent kept");
    check("R7 conflict cnt", int'(cnt_conflict_o), 1);
  endtask

  task automatic t_lru_refresh();
    do_reset();
    access(8'h00, K_COMP, "R6 a");
    access(8'h04, K_COMP, "R6 b");
    access(8'h08, K_COMP, "R6 c");
    access(8'h0C, K_COMP, "R6 d");
    access(8'h00, K_HIT, "R6 refresh a");
    access(8'h10, K_COMP, "R6 evict b");
    access(8'h00, K_HIT, "R6 refreshed kept");
    access(8'h04, K_CONF, "R3 lru victim");
  endtask

  task automatic t_capacity();
    do_reset();
    for (int i = 0; i < 17; i++) access(8'(i), K_COMP, "R4 sweep");
    check("R7 compulsory cnt sweep", int'(cnt_compulsory_o), 17);
    access(8'h00, K_CAP, "R5 both evicted");
    check("R7 capacity cnt", int'(cnt_capacity_o), 1);
  endtask

  task automatic t_reset_history();
    do_reset();
    access(8'h22, K_COMP, "R8 before reset");
    do_reset();
    access(8'h22, K_COMP, "R8 history cleared");
  endtask

  task automatic t_saturate();
    do_reset();
    access(8'h05, K_COMP, "R4 sat prep");
    @(negedge clk);
    addr_valid_i = 1'b1; addr_i = 8'h05;
    for (int i = 0; i < 65540; i++) @(negedge clk);
    addr_valid_i = 1'b0;
    check("R7 saturated valid", int'(res_valid_o), 1);
    check("R7 hit saturates", int'(cnt_hit_o), 65535);
    @(negedge clk);
    check("R7 hit holds", int'(cnt_hit_o), 65535);
    check("R7 others untouched", int'(cnt_compulsory_o), 1);
  endtask

  initial begin
    t_reset_state();
    t_first_then_hit();
    t_idle();
    t_fill_and_conflict();
    t_lru_refresh();
    t_capacity();
    t_reset_history();
    t_saturate();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule